// File: doc/BRIEF.md
# Prescaled Modulo Timer

This block is a 16-bit up-counter for general timing. Each count is gated by an enable from a selectable source. The source is either one of seven power-of-two divisions of the bus clock, taken from a free-running 6-bit prescaler, or the rising edges of an external clock pin. The pin is synchronised into the bus clock domain before use. The counter runs up to a programmable modulo value and then returns to zero. On that wrap it raises an overflow flag. The flag drives an interrupt request when the interrupt enable is set.

Software controls the timer through a byte-wide register port. One status/control byte holds the following bits:
- the overflow flag
- the interrupt enable
- a stop bit, which is set out of reset so the timer is idle until software releases it
- a write-only pulse that clears the counter and the prescaler together
- the 3-bit clock-source select

The other registers hold the live counter bytes and the modulo bytes. A capture-inhibit output follows the stop bit, so that capture logic outside this block can hold off while the timer is halted.

The overflow flag is tracked by a three-state machine:
- **FLG_CLEAR**: no overflow is pending.
- **FLG_SET**: an overflow is pending and has not yet been seen by a read.
- **FLG_ARMED**: software has read the status byte while the flag was set.

Its transitions are:
- CLEAR→SET on an overflow.
- SET→ARMED on a status read with no overflow in the same cycle.
- ARMED→SET on a new overflow.
- ARMED→CLEAR on a status write with the flag bit at 0 and no overflow in that cycle.

Any other event holds the current state.

Top module: `pmt_timer`

## Requirements
- R1: After reset, the following hold:
  - The status byte (offset 0) reads 0x20, which is the stop bit only.
  - The counter bytes (offsets 1 = high, 2 = low) read 0.
  - The modulo bytes (offsets 3 = high, 4 = low) read 0xFF each.
  - `irq` is 0 and `cap_inhibit` is 1.
- R2: Status bit 5 is the stop bit. While it is 1, the counter holds its value and `cap_inhibit` is 1. The cycle a write clears it, the counter does not yet move. From the next count enable on, counting resumes and `cap_inhibit` is 0.
- R3: Status bits 2:0 select the count source. Code k in 0..6 gives one count enable every 2^k bus cycles. After a reset pulse (bit 4), the first enable falls 2^k edges after the edge of that write.
- R4: Select code 7 counts rising edges of `ext_clk`. A rise set up before bus edge 1 advances the counter at edge 3.
- R5: On a count enable while the counter equals the modulo value, the counter returns to 0x0000. Otherwise a count enable adds one.
- R6: The overflow flag (status bit 7) becomes 1 on the edge where the counter wraps from the modulo value to zero.
- R7: The flag clears only through a status write with bit 7 at 0 that follows a status read made while the flag was 1. Neither of the following changes the flag:
  - a write of 0 to bit 7 without that earlier read;
  - a write of 1 to bit 7.
- R8: If an overflow occurs between the arming read and the clearing write, the flag stays 1.
- R9: Status bit 6 is the interrupt enable. `irq` is 1 exactly when the flag and the enable are both 1.
- R10: Writing 1 to status bit 4 clears the counter and the prescaler on that edge. It leaves the flag, the enable, the select and the modulo unchanged. Bit 4 always reads 0.
- R11: A single status write with both bit 5 and bit 4 at 1 leaves the counter halted at 0x0000.
- R12: Status bit 3 reads 0. Offsets 5 to 7 read 0x00. The modulo bytes read back what was written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, applied at the clock edge |
| rd_en | input | 1 | Read strobe; a status read with it arms the flag clear |
| rdata | output | 8 | Read data, combinational from `addr` |
| ext_clk | input | 1 | External count clock, asynchronous |
| irq | output | 1 | Overflow interrupt request |
| cap_inhibit | output | 1 | Capture-inhibit qualifier, high while stopped |
| count_out | output | 16 | Live counter value |

## Verification
A register write takes effect on the clock edge that samples its strobe. The effects of that write, whether on the counter, the flag or `irq`, are therefore visible from the following falling edge. Read data is combinational and is sampled just before the edge that commits the read. Divided counts follow the write of the reset bit: after n further edges the counter holds (n >> k) mod (modulo+1), and the flag is set once n >> k exceeds the modulo. The bench computes these values and samples at the falling edge after exactly n rising edges. External counts land on the third rising edge after the pin rises, and the bench checks the counter both before and at that edge.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

    typedef enum logic [1:0] {
        FLG_CLEAR = 2'd0,
        FLG_SET   = 2'd1,
        FLG_ARMED = 2'd2
    } flag_state_e;

    localparam int unsigned ADR_CTRL   = 0;
    localparam int unsigned ADR_CNT_HI = 1;
    localparam int unsigned ADR_CNT_LO = 2;
    localparam int unsigned ADR_MOD_HI = 3;
    localparam int unsigned ADR_MOD_LO = 4;

    localparam int unsigned BIT_FLAG = 7;
    localparam int unsigned BIT_IE   = 6;
    localparam int unsigned BIT_STOP = 5;
    localparam int unsigned BIT_RST  = 4;

endpackage

// File: rtl/pmt_prescale.sv
module pmt_prescale #(
    parameter int unsigned STAGES = 6,
    parameter int unsigned SEL_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    input  logic             ext_rise,
    output logic             tick
);
    localparam int unsigned TAPS = 1 << SEL_W;

    logic [STAGES-1:0] psc_q;
    logic [TAPS-1:0]   tap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_q <= '0;
        end else if (clr) begin
            psc_q <= '0;
        end else begin
            psc_q <= psc_q + STAGES'(1);
        end
    end

    // tap k fires once every 2^k cycles; codes above the divider chain use the pin
    generate
        for (genvar k = 0; k < TAPS; k++) begin : g_tap
            if (k == 0) begin : g_div1
                assign tap[k] = 1'b1;
            end else if (k <= STAGES) begin : g_divn
                assign tap[k] = &psc_q[k-1:0];
            end else begin : g_ext
                assign tap[k] = ext_rise;
            end
        end
    endgenerate

    assign tick = tap[sel];

endmodule

// File: rtl/pmt_edge_sync.sv
module pmt_edge_sync #(
    parameter int unsigned SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [SYNC-1:0] sync_q;
    logic            last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC-2:0], din};
            last_q <= sync_q[SYNC-1];
        end
    end

    assign rise = sync_q[SYNC-1] & ~last_q;

endmodule

// File: rtl/pmt_counter.sv
module pmt_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         ce,
    input  logic [W-1:0] modulo,
    output logic [W-1:0] count,
    output logic         ovf
);
    logic [W-1:0] count_q;
    logic         at_mod;

    assign at_mod = (count_q == modulo);
    assign ovf    = ce & ~clr & at_mod;
    assign count  = count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr) begin
            count_q <= '0;
        end else if (ce) begin
            count_q <= at_mod ? '0 : count_q + W'(1);
        end
    end

endmodule

// File: rtl/pmt_flag_fsm.sv
module pmt_flag_fsm
    import pmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ovf,
    input  logic status_rd,
    input  logic clr_wr,
    input  logic ie,
    output logic flag,
    output logic irq
);
    flag_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_CLEAR: if (ovf) state_d = FLG_SET;
            FLG_SET:   if (!ovf && status_rd) state_d = FLG_ARMED;
            FLG_ARMED: begin
                if (ovf)         state_d = FLG_SET;
                else if (clr_wr) state_d = FLG_CLEAR;
            end
            default:   state_d = FLG_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        flag = (state_q != FLG_CLEAR);
        irq  = flag & ie;
    end

endmodule

// File: rtl/pmt_timer.sv
module pmt_timer
    import pmt_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned ADDR_W      = 3,
    parameter int unsigned PS_STAGES   = 6,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                wr_en,
    input  logic                rd_en,
    output logic [DATA_W-1:0]   rdata,
    input  logic                ext_clk,
    output logic                irq,
    output logic                cap_inhibit,
    output logic [2*DATA_W-1:0] count_out
);
    localparam int unsigned CNT_W = 2 * DATA_W;
    localparam int unsigned SEL_W = $clog2(PS_STAGES + 2);

    logic             ie_q;
    logic             stop_q;
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] mod_q;

    logic ctrl_wr, status_rd, flag_clr_wr, trst_pulse;
    logic ext_rise, tick, ce, ovf, flag;
    logic ctrl_unused;

    assign ctrl_wr     = wr_en && (addr == ADDR_W'(ADR_CTRL));
    assign status_rd   = rd_en && (addr == ADDR_W'(ADR_CTRL));
    assign flag_clr_wr = ctrl_wr && !wdata[BIT_FLAG];
    assign trst_pulse  = ctrl_wr && wdata[BIT_RST];
    assign ctrl_unused = wdata[3];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q   <= 1'b0;
            stop_q <= 1'b1;
            sel_q  <= '0;
            mod_q  <= '1;
        end else if (wr_en) begin
            if (addr == ADDR_W'(ADR_CTRL)) begin
                ie_q   <= wdata[BIT_IE];
                stop_q <= wdata[BIT_STOP];
                sel_q  <= wdata[SEL_W-1:0];
            end
            if (addr == ADDR_W'(ADR_MOD_HI)) mod_q[CNT_W-1:DATA_W] <= wdata;
            if (addr == ADDR_W'(ADR_MOD_LO)) mod_q[DATA_W-1:0]     <= wdata;
        end
    end

    pmt_edge_sync #(.SYNC(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ext_clk),
        .rise (ext_rise)
    );

    pmt_prescale #(.STAGES(PS_STAGES), .SEL_W(SEL_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (trst_pulse),
        .sel     (sel_q),
        .ext_rise(ext_rise),
        .tick    (tick)
    );

    assign ce = tick & ~stop_q;

    pmt_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (trst_pulse),
        .ce    (ce),
        .modulo(mod_q),
        .count (count_out),
        .ovf   (ovf)
    );

    pmt_flag_fsm u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .ovf      (ovf),
        .status_rd(status_rd),
        .clr_wr   (flag_clr_wr),
        .ie       (ie_q),
        .flag     (flag),
        .irq      (irq)
    );

    assign cap_inhibit = stop_q;

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(ADR_CTRL): begin
                rdata[BIT_FLAG]  = flag;
                rdata[BIT_IE]    = ie_q;
                rdata[BIT_STOP]  = stop_q;
                rdata[SEL_W-1:0] = sel_q;
            end
            ADDR_W'(ADR_CNT_HI): rdata = count_out[CNT_W-1:DATA_W];
            ADDR_W'(ADR_CNT_LO): rdata = count_out[DATA_W-1:0];
            ADDR_W'(ADR_MOD_HI): rdata = mod_q[CNT_W-1:DATA_W];
            ADDR_W'(ADR_MOD_LO): rdata = mod_q[DATA_W-1:0];
            default:             rdata = '0;
        endcase
    end

endmodule

// File: rtl/pmt_timer_chk.sv
module pmt_timer_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] count_out,
    input logic [CNT_W-1:0] mod_q,
    input logic             ce,
    input logic             stop_q,
    input logic             trst_pulse,
    input logic             flag,
    input logic             flag_clr_wr
);
    // R2
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q && !trst_pulse) |=> $stable(count_out));

    // R10
    trst_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trst_pulse |=> (count_out == '0));

    // R5
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !trst_pulse && count_out == mod_q) |=> (count_out == '0));

    // R5
    step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !trst_pulse && count_out != mod_q) |=> (count_out == $past(count_out) + CNT_W'(1)));

    // R6
    wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !trst_pulse && count_out == mod_q) |=> flag);

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr_wr) |=> flag);

endmodule

bind pmt_timer pmt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .count_out  (count_out),
    .mod_q      (mod_q),
    .ce         (ce),
    .stop_q     (stop_q),
    .trst_pulse (trst_pulse),
    .flag       (flag),
    .flag_clr_wr(flag_clr_wr)
);

// File: tb/pmt_timer_tb.sv
module pmt_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rdata;
    logic        ext_clk = 1'b0;
    logic        irq;
    logic        cap_inhibit;
    logic [15:0] count_out;

    int unsigned checks = 0;
    int unsigned fails  = 0;
    bit          done   = 1'b0;

    always #4 clk = ~clk;

    pmt_timer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .wdata      (wdata),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .rdata      (rdata),
        .ext_clk    (ext_clk),
        .irq        (irq),
        .cap_inhibit(cap_inhibit),
        .count_out  (count_out)
    );

    task automatic check(input string req, input int unsigned act, input int unsigned exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    function automatic int unsigned exp_count(int unsigned n, int unsigned k, int unsigned m);
        return (n >> k) % (m + 1);
    endfunction

    function automatic bit exp_flag(int unsigned n, int unsigned k, int unsigned m);
        return (n >> k) > m;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(3'd0, d); check("R1 status", d, 8'h20);
        peek(3'd1, d); check("R1 cnt hi", d, 0);
        peek(3'd2, d); check("R1 cnt lo", d, 0);
        peek(3'd3, d); check("R1 mod hi", d, 8'hFF);
        peek(3'd4, d); check("R1 mod lo", d, 8'hFF);
        check("R1 irq", irq, 0);
        check("R1 cap_inhibit", cap_inhibit, 1);
        idle(10);
        check("R2 held after reset", count_out, 0);

        // R6 wrap and flag with modulo 3, divide by 1
        wr(3'd3, 8'h00); wr(3'd4, 8'h03);
        wr(3'd0, 8'h50);
        idle(3);
        check("R5 count before wrap", count_out, 3);
        check("R6 no flag before wrap", irq, 0);
        idle(1);
        check("R5 wrapped to zero", count_out, 0);
        check("R6 flag on wrap", irq, 1);

        // R7 clear protocol
        wr(3'd0, 8'hE0);
        check("R7 write 1 keeps flag", irq, 1);
        wr(3'd0, 8'h60);
        check("R7 write 0 without read keeps flag", irq, 1);
        rd(3'd0, d);
        check("R7 status read", d, 8'hE0);
        wr(3'd0, 8'hE0);
        check("R7 armed, write 1 keeps flag", irq, 1);
        wr(3'd0, 8'h60);
        check("R7 read then write 0 clears", irq, 0);
        peek(3'd0, d); check("R7 status after clear", d, 8'h60);

        // R8 overflow between read and write
        wr(3'd0, 8'h50);
        idle(4);
        check("R8 flag set", irq, 1);
        rd(3'd0, d);
        idle(4);
        wr(3'd0, 8'h60);
        check("R8 overflow after read keeps flag", irq, 1);
        rd(3'd0, d);
        wr(3'd0, 8'h60);
        check("R8 clean clear", irq, 0);

        // R9 enable gating
        wr(3'd0, 8'h10);
        idle(4);
        check("R9 flag without enable", irq, 0);
        peek(3'd0, d); check("R9 flag visible", d, 8'h80);
        wr(3'd0, 8'hC0);
        check("R9 enable raises irq", irq, 1);

        // R10 reset pulse
        wr(3'd3, 8'h12); wr(3'd4, 8'h34);
        wr(3'd0, 8'hD2);
        check("R10 counter cleared", count_out, 0);
        peek(3'd0, d); check("R10 other bits kept, bit4 reads 0", d, 8'hC2);
        peek(3'd3, d); check("R12 mod hi readback", d, 8'h12);
        peek(3'd4, d); check("R12 mod lo readback", d, 8'h34);
        idle(3);
        check("R10 prescaler restarted", count_out, 0);
        idle(1);
        check("R3 divide by 4 first tick", count_out, 1);
        check("R10 flag kept", irq, 1);

        // R11 stop and reset together
        wr(3'd0, 8'h30);
        check("R11 parked at zero", count_out, 0);
        idle(20);
        check("R11 still zero", count_out, 0);
        check("R2 inhibit while stopped", cap_inhibit, 1);

        // R4 external clock
        wr(3'd0, 8'h17);
        ext_clk = 1'b1;
        idle(2);
        check("R4 not yet counted", count_out, 0);
        idle(1);
        check("R4 counted at third edge", count_out, 1);
        ext_clk = 1'b0; idle(3);
        for (int i = 0; i < 4; i++) begin
            ext_clk = 1'b1; idle(3);
            ext_clk = 1'b0; idle(3);
        end
        check("R4 five edges", count_out, 5);

        // R2 stop blocks external counts, then resume
        wr(3'd0, 8'h27);
        ext_clk = 1'b1; idle(3);
        ext_clk = 1'b0; idle(3);
        check("R2 stopped holds", count_out, 5);
        check("R2 inhibit set", cap_inhibit, 1);
        wr(3'd0, 8'h30);
        wr(3'd0, 8'h00);
        check("R2 no count on release edge", count_out, 0);
        check("R2 inhibit cleared", cap_inhibit, 0);
        idle(1);
        check("R2 resumes", count_out, 1);
        idle(5);
        check("R3 divide by 1", count_out, 6);

        // R12 unused space
        peek(3'd5, d); check("R12 offset 5", d, 0);
        peek(3'd6, d); check("R12 offset 6", d, 0);
        peek(3'd7, d); check("R12 offset 7", d, 0);

        // random division, modulo and run length
        for (int v = 0; v < 24; v++) begin
            int unsigned k, m, n;
            bit ie;
            k  = $urandom % 4;
            m  = $urandom % 40 + 1;
            n  = $urandom % 200 + 1;
            ie = 1'($urandom % 2);
            wr(3'd0, 8'hA0);
            rd(3'd0, d);
            wr(3'd0, 8'h30);
            check("R7 clear before vector", irq, 0);
            wr(3'd3, 8'(m >> 8)); wr(3'd4, 8'(m));
            wr(3'd0, {1'b0, ie, 1'b0, 1'b1, 1'b0, 3'(k)});
            idle(n);
            check("R3/R5 random count", count_out, exp_count(n, k, m));
            check("R6/R9 random irq", irq, ie & exp_flag(n, k, m));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule